// File: doc/BRIEF.md
# Two-Buffer Transmit Frame Controller

This block holds two 2 KB packet buffers, called ping (at offset 0x000) and pong (at offset 0x800), behind a simple word-wide write/read register port. Software fills a buffer with frame bytes, writes the frame's byte count into that buffer's length register, and then sets the busy bit in the buffer's status register. The block sends the frame as a byte stream with valid/ready handshaking. The stream carries no preamble and no CRC. When the last byte has been accepted, the block clears busy and may pulse an interrupt. A single transmit engine serves both buffers. When both are waiting, they go out in the order they were armed.

The status register also accepts a program command. Setting busy and program together makes the engine copy the first six bytes of that buffer into the station address output, and it sends nothing. Writing a status value whose busy bit is zero returns the buffer to idle at once. If that buffer is on the stream at that moment, its frame is cut short.

The two buffers share one address layout. Inside either buffer, the status register sits at 0x7FC, the length register at 0x7F4 and the global interrupt enable at 0x7F8 (ping side only). Every lower offset is buffer RAM. Bit 11 of the byte address selects the buffer.

Top module: `txpp_ctrl`

## Requirements
- R1: After reset both status registers read 0, tx_valid and irq are low, and mac_addr is zero.
- R2: A frame of N bytes (N > 0) leaves as exactly N stream handshakes. Byte i comes from RAM word i/4 of the buffer, lane (i mod 4) counted from the most significant byte (bits 31:24 first). Lanes of a partial final word that lie beyond N are never sent. tx_last is high only on byte N-1.
- R3: While tx_valid is high and tx_ready is low, tx_data and tx_last hold their values and tx_valid stays high.
- R4: The busy bit (status bit 0) reads 1 while the frame is pending or sending. It reads 0 once the last byte has been accepted, and the interrupt-enable bit keeps its value.
- R5: The status register at buffer offset 0x7FC reads busy in bit 0, program in bit 1, interrupt enable in bit 3 and the software flag in bit 31, with all other bits 0. The length register at 0x7F4 keeps only the low 16 bits, and its upper bits read 0. Buffer RAM reads back the words that were written.
- R6: A status write with bit 0 and bit 1 both set, to an idle buffer, loads mac_addr with bytes 0..5 of the buffer, byte 0 in bits 47:40. It puts no byte on the stream and leaves bits 0 and 1 cleared.
- R7: A status write with bit 0 clear makes the buffer idle. If that buffer is being sent, tx_valid drops on the next cycle and the rest of the frame is never sent.
- R8: A status write with bit 0 set is refused, and busy stays 0, when the buffer's busy bit or its stored software flag (bit 31) is already 1.
- R9: When both buffers are armed, the frames leave one after the other, in the order their busy bits were set, with no interleaving.
- R10: On completion of a frame, irq pulses high for exactly one cycle only when that buffer's bit 3 is 1 and the global enable (ping offset 0x7F8, bit 31) is 1. A program command raises no interrupt.
- R11: A frame with length 0 completes without any stream byte, clears busy and raises the interrupt under the rule of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one 32-bit word |
| bus_addr | input | 12 | Byte address; bit 11 selects pong |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Stream sink accepts the byte |
| irq | output | 1 | One-cycle completion pulse |
| mac_addr | output | 48 | Station address loaded by the program command |

## Verification
The assertions check the following on every cycle:
- The stream is only driven for a busy buffer that is not in program mode.
- A stalled byte stays stable.
- Busy falls right after the last handshake and after a program step.
- irq is a single-cycle pulse that needs the global enable.

Only the bench scenarios can show the following:
- The byte order and truncation within words.
- That the two buffers are served in arming order.
- The station address value after a program command.
- That refused, aborted and zero-length cases leave the stream silent.

// File: rtl/txpp_ctrl.sv
`timescale 1ns/1ps
module txpp_ctrl #(
  parameter int BUF_BYTES = 2048,
  parameter int LEN_W     = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bus_wr,
  input  logic [$clog2(BUF_BYTES):0]         bus_addr,
  input  logic [31:0]                        bus_wdata,
  output logic [31:0]                        bus_rdata,
  output logic [7:0]                         tx_data,
  output logic                               tx_valid,
  output logic                               tx_last,
  input  logic                               tx_ready,
  output logic                               irq,
  output logic [47:0]                        mac_addr
);
  localparam int OFFW  = $clog2(BUF_BYTES);
  localparam int AW    = OFFW + 1;
  localparam int WIDX  = OFFW - 2;
  localparam int DEPTH = 2 * (BUF_BYTES / 4);
  localparam logic [OFFW-1:0] LEN_OFF  = OFFW'(BUF_BYTES - 12);
  localparam logic [OFFW-1:0] GIE_OFF  = OFFW'(BUF_BYTES - 8);
  localparam logic [OFFW-1:0] STAT_OFF = OFFW'(BUF_BYTES - 4);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_PROG} eng_t;

  logic [31:0]      mem [DEPTH];
  logic [1:0]       busy, prog, ie, act;
  logic [LEN_W-1:0] len [2];
  logic             gie, older, cur;
  eng_t             state;
  logic [LEN_W-1:0] cnt;

  wire            wb       = bus_addr[AW-1];
  wire [OFFW-1:0] woff     = bus_addr[OFFW-1:0];
  wire            is_stat  = woff == STAT_OFF;
  wire            is_len   = woff == LEN_OFF;
  wire            is_gie   = woff == GIE_OFF;
  wire            is_data  = woff < LEN_OFF;

  wire            sel      = (busy == 2'b11) ? older : busy[1];
  wire            eng_live = (state != S_IDLE) || (busy != 2'b00);
  wire            eng_buf  = (state == S_IDLE) ? sel : cur;
  wire            stat_wr  = bus_wr && is_stat;
  wire            abort_hit = stat_wr && !bus_wdata[0] && eng_live && (eng_buf == wb);
  wire            start_ok  = stat_wr && bus_wdata[0] && !busy[wb] && !act[wb];

  wire [LEN_W-1:0] send_len = len[cur];
  wire [31:0]      cur_word = mem[{cur, cnt[OFFW-1:2]}];
  wire [31:0]      shifted  = cur_word >> {~cnt[1:0], 3'b000};

  assign tx_valid = (state == S_SEND) && (send_len != '0);
  assign tx_data  = shifted[7:0];
  assign tx_last  = tx_valid && ((cnt + 1'b1) == send_len);

  wire frame_done = (state == S_SEND) && ((send_len == '0) || (tx_ready && tx_last));

  always_ff @(posedge clk) begin
    if (bus_wr && is_data)
      mem[{wb, woff[OFFW-1:2]}] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (is_stat) begin
      bus_rdata <= {act[wb], 27'd0, ie[wb], 1'b0, prog[wb], busy[wb]};
    end else if (is_len) begin
      bus_rdata <= 32'(len[wb]);
    end else if (is_gie) begin
      bus_rdata <= {gie && !wb, 31'd0};
    end else begin
      bus_rdata <= mem[{wb, woff[OFFW-1:2]}];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= '0;
      prog     <= '0;
      ie       <= '0;
      act      <= '0;
      len[0]   <= '0;
      len[1]   <= '0;
      gie      <= 1'b0;
      older    <= 1'b0;
      cur      <= 1'b0;
      cnt      <= '0;
      state    <= S_IDLE;
      irq      <= 1'b0;
      mac_addr <= '0;
    end else begin
      irq <= 1'b0;
      case (state)
        S_IDLE: begin
          if (busy != 2'b00) begin
            cur   <= sel;
            cnt   <= '0;
            state <= prog[sel] ? S_PROG : S_SEND;
          end
        end
        S_SEND: begin
          if (frame_done) begin
            busy[cur] <= 1'b0;
            irq       <= ie[cur] && gie;
            state     <= S_IDLE;
          end else if (tx_ready) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PROG: begin
          mac_addr   <= {mem[{cur, {WIDX{1'b0}}}], mem[{cur, WIDX'(1)}][31:16]};
          busy[cur]  <= 1'b0;
          prog[cur]  <= 1'b0;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase

      if (bus_wr) begin
        if (is_stat) begin
          ie[wb]  <= bus_wdata[3];
          act[wb] <= bus_wdata[31];
          if (!bus_wdata[0]) begin
            busy[wb] <= 1'b0;
            prog[wb] <= 1'b0;
          end else if (start_ok) begin
            busy[wb] <= 1'b1;
            prog[wb] <= bus_wdata[1];
            if (!busy[~wb]) older <= wb;
          end
          if (abort_hit) begin
            state <= S_IDLE;
            irq   <= 1'b0;
          end
        end else if (is_len) begin
          len[wb] <= bus_wdata[LEN_W-1:0];
        end else if (is_gie && !wb) begin
          gie <= bus_wdata[31];
        end
      end
    end
  end

  AST_TX_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (busy[cur] && !prog[cur])); // R2

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !bus_wr) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R3

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last && !bus_wr) |=> !busy[$past(cur)]); // R4

  AST_PROG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PROG && !bus_wr) |=> (!busy[$past(cur)] && !prog[$past(cur)])); // R6

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R10

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(gie)); // R10

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> !tx_valid); // R7
endmodule

// File: tb/txpp_ctrl_bench.sv
`timescale 1ns/1ps
module txpp_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire  [7:0]  tx_data;
  wire         tx_valid, tx_last, irq;
  logic        tx_ready = 1'b0;
  wire  [47:0] mac_addr;

  txpp_ctrl u_txpp_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
    .irq(irq), .mac_addr(mac_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, fails = 0, rmode = 0, cyc = 0, irq_cnt = 0;
  logic [8:0] exp_q [$];
  logic       held = 1'b0;
  logic [8:0] held_v = '0;

  task automatic chk(string req, logic [63:0] a, logic [63:0] e);
    total++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, a, e);
    end
  endtask

  always @(negedge clk) begin
    logic [8:0] e;
    cyc++;
    if (irq) irq_cnt++;
    if (held && tx_valid) chk("R3 stalled byte held", {55'd0, tx_last, tx_data}, {55'd0, held_v});
    tx_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? (cyc % 3 != 0) : 1'b0;
    held   = tx_valid && !tx_ready;
    held_v = {tx_last, tx_data};
    if (tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        total++; fails++;
        $display("FAIL R2 unexpected byte actual %0h expected none", {tx_last, tx_data});
      end else begin
        e = exp_q.pop_front();
        chk("R2 stream byte/last", {55'd0, tx_last, tx_data}, {55'd0, e});
      end
    end
  end

  function automatic logic [7:0] bval(logic [7:0] seed, int i);
    return 8'(seed + 8'(i * 37));
  endfunction

  function automatic logic [31:0] pack(logic [7:0] seed, int n, int w);
    logic [31:0] r = '0;
    for (int l = 0; l < 4; l++)
      r[31-8*l -: 8] = (w*4+l < n) ? bval(seed, w*4+l) : 8'hEE;
    return r;
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [11:0] base(bit b);
    return b ? 12'h800 : 12'h000;
  endfunction

  task automatic load_frame(bit b, int n, logic [7:0] seed);
    for (int w = 0; w < (n + 3) / 4; w++)
      wr(base(b) | 12'(w*4), pack(seed, n, w));
    wr(base(b) | 12'h7F4, 32'(n));
  endtask

  task automatic arm(bit b, logic [31:0] st, int n, logic [7:0] seed);
    for (int i = 0; i < n; i++) exp_q.push_back({(i == n-1), bval(seed, i)});
    wr(base(b) | 12'h7FC, st);
  endtask

  task automatic wait_idle(bit b);
    logic [31:0] s;
    for (int k = 0; k < 4000; k++) begin
      rd(base(b) | 12'h7FC, s);
      if (!s[0]) break;
    end
  endtask

  initial begin
    logic [31:0] s;
    int i0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_valid after reset", 64'(tx_valid), 0);
    chk("R1 irq after reset", 64'(irq), 0);
    chk("R1 mac after reset", 64'(mac_addr), 0);
    rd(12'h7FC, s); chk("R1 ping status", 64'(s), 0);
    rd(12'hFFC, s); chk("R1 pong status", 64'(s), 0);

    wr(12'h7F8, 32'h8000_0000);
    rd(12'h7F8, s); chk("R10 global enable readback", 64'(s), 64'h8000_0000);

    rmode = 1;
    load_frame(0, 9, 8'h10);
    i0 = irq_cnt;
    arm(0, 32'h9, 9, 8'h10);
    rd(12'h7FC, s); chk("R5 R4 status while sending", 64'(s), 64'h9);
    wait_idle(0);
    chk("R2 all bytes sent", 64'(exp_q.size()), 0);
    rd(12'h7FC, s); chk("R4 busy cleared, ie kept", 64'(s), 64'h8);
    chk("R10 one irq with ie and gie", 64'(irq_cnt - i0), 1);
    rd(12'h004, s); chk("R5 RAM readback", 64'(s), 64'(pack(8'h10, 9, 1)));

    wr(12'hFF4, 32'hABCD_0005);
    rd(12'hFF4, s); chk("R5 length upper bits dropped", 64'(s), 5);

    load_frame(1, 5, 8'h40);
    i0 = irq_cnt;
    arm(1, 32'h1, 5, 8'h40);
    wait_idle(1);
    chk("R2 pong bytes sent", 64'(exp_q.size()), 0);
    chk("R10 no irq with ie clear", 64'(irq_cnt - i0), 0);

    rmode = 1;
    load_frame(1, 12, 8'h60);
    load_frame(0, 8, 8'h80);
    arm(1, 32'h1, 12, 8'h60);
    arm(0, 32'h1, 8, 8'h80);
    wait_idle(1);
    wait_idle(0);
    chk("R9 both frames sent in arming order", 64'(exp_q.size()), 0);

    rmode = 0;
    wr(12'h7F8, 32'h0);
    load_frame(0, 4, 8'h90);
    i0 = irq_cnt;
    arm(0, 32'h9, 4, 8'h90);
    wait_idle(0);
    chk("R10 no irq with gie clear", 64'(irq_cnt - i0), 0);
    wr(12'h7F8, 32'h8000_0000);

    wr(12'h000, 32'h0211_2233);
    wr(12'h004, 32'h4455_AABB);
    i0 = irq_cnt;
    wr(12'h7FC, 32'hB);
    wait_idle(0);
    chk("R6 station address", 64'(mac_addr), 64'h0211_2233_4455);
    rd(12'h7FC, s); chk("R6 busy and program cleared", 64'(s), 64'h8);
    chk("R6 no irq on program", 64'(irq_cnt - i0), 0);

    wr(12'h7F4, 32'h0);
    i0 = irq_cnt;
    arm(0, 32'h9, 0, 8'h00);
    wait_idle(0);
    rd(12'h7FC, s); chk("R11 zero length done", 64'(s), 64'h8);
    chk("R11 irq on zero length", 64'(irq_cnt - i0), 1);

    load_frame(1, 4, 8'h33);
    wr(12'hFFC, 32'h8000_0000);
    wr(12'hFFC, 32'h8000_0001);
    rd(12'hFFC, s); chk("R8 start refused with flag set", 64'(s), 64'h8000_0000);
    repeat (6) @(negedge clk);
    chk("R8 stream idle after refusal", 64'(tx_valid), 0);
    wr(12'hFFC, 32'h0);

    rmode = 2;
    load_frame(0, 40, 8'hA0);
    wr(12'h7FC, 32'h1);
    repeat (3) @(negedge clk);
    chk("R7 frame on stream before abort", 64'(tx_valid), 1);
    wr(12'h7FC, 32'h0);
    chk("R7 stream dropped after abort", 64'(tx_valid), 0);
    rd(12'h7FC, s); chk("R7 status idle after abort", 64'(s), 0);
    rmode = 0;
    repeat (10) @(negedge clk);
    chk("R7 no resume after abort", 64'(tx_valid), 0);

    load_frame(0, 3, 8'hC0);
    arm(0, 32'h1, 3, 8'hC0);
    wait_idle(0);
    chk("R7 next frame after abort", 64'(exp_q.size()), 0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule